// File: doc/BRIEF.md
# Codec Master and Serial Clock Enable Divider

This block derives every internal timing enable of a codec from a single fast clock. It runs entirely in the domain of that clock. It produces no divided clock waveform, only one-cycle enable pulses.

A programmable master divider first thins the clock into a device tick. The divide ratio can be 1 to 5, so odd ratios are included. Every other strobe counts device ticks, never raw clock cycles:

- A selectable power-of-two stage gives the serial-shift enable at 1, 2, 4 or 8 device ticks.
- A fixed stage gives the modulator bit enable every 8 device ticks.
- A second fixed stage gives the sample-event strobe every 256 device ticks.

Ratio changes are staged. A new master code waits for the end of the master period in progress. A new serial code waits for the end of the serial period in progress. As a result, no enable ever arrives early.

Top module: `codec_clock_enables`

## Requirements
- R1: While `rst_n` is low, all four enable outputs are 0. After release, the master ratio and the serial ratio both start at 1, so `dev_ce` and `ser_ce` are high in the first cycle after reset.
- R2: Master code values 0, 1, 2, 3 and 4 select divide ratios 1, 2, 3, 4 and 5. `dev_ce` is high for exactly one cycle in every N clock cycles.
- R3: Master code values 5, 6 and 7 select divide by 1.
- R4: A master code change takes effect only when `dev_ce` is high. The device period in progress completes at the old ratio.
- R5: Serial code values 0, 1, 2 and 3 select a `ser_ce` pulse every 1, 2, 4 or 8 `dev_ce` pulses. `ser_ce` is high only in a cycle in which `dev_ce` is also high.
- R6: A serial code change takes effect only when `ser_ce` is high. The serial period in progress completes at the old ratio.
- R7: `mod_ce` is high on every 8th `dev_ce` pulse, counted from reset, and only together with `dev_ce`.
- R8: `smp_ce` is high on every 256th `dev_ce` pulse, counted from reset, and only together with `mod_ce`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | External master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mdiv_code | input | 3 | Master divider code (0..4 selects ratio 1..5, 5..7 selects 1) |
| sdiv_code | input | 2 | Serial divider code (ratio is 2 to the power of the code, in device ticks) |
| dev_ce | output | 1 | Device clock enable |
| ser_ce | output | 1 | Serial shift enable |
| mod_ce | output | 1 | Modulator bit enable (device rate / 8) |
| smp_ce | output | 1 | Sample event strobe (device rate / 256) |

## Verification
Every output is decoded combinationally from registered state, so a code presented before a clock edge can change the outputs only in the cycle after that edge. It changes them only if that edge closes a period of the affected divider.

The bench drives its inputs and samples the outputs on the falling edge. A behavioural model advances on the same rising edge as the design and predicts all four enables for the following cycle. The model and the design are compared in every cycle.

Code changes are timed to land in the middle of a period. The staged ratio must then wait one or more further cycles before it shows, and the comparison catches a ratio applied early.

// File: rtl/codec_clk_pkg.sv
package codec_clk_pkg;

   // Widths of the control fields fed into the block
   localparam int MDIV_CODE_W = 3;
   localparam int SDIV_CODE_W = 2;

   // Highest master ratio decoded from the master code
   localparam int MDIV_MAX    = 5;

   // Fixed power-of-two stages (log2 of device ticks per pulse)
   localparam int MOD_LOG2    = 3;
   localparam int SMP_LOG2    = 8;

   // Terminal count for a master code; unused codes fall back to divide by 1
   function automatic int unsigned mdiv_limit(input int unsigned code, input int unsigned max_ratio);
      if (code < max_ratio) return code;
      return 0;
   endfunction

endpackage

// File: rtl/ccd_master_div.sv
module ccd_master_div #(
   parameter int CODE_W    = 3,
   parameter int MAX_RATIO = 5,
   localparam int CNT_W    = (MAX_RATIO > 1) ? $clog2(MAX_RATIO) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] code,
   output logic              tick
);
   import codec_clk_pkg::*;

   generate
      if (MAX_RATIO < 1 || MAX_RATIO > (1 << CODE_W)) begin : g_bad_ratio
         $error("ccd_master_div: MAX_RATIO out of range for CODE_W");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] lim_q;
   logic [CNT_W-1:0] lim_next;

   always_comb begin
      lim_next = CNT_W'(mdiv_limit(int'(code), MAX_RATIO));
   end

   assign tick = (cnt_q == lim_q);

   // The ratio in use is replaced only at the terminal count
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         lim_q <= '0;
      end else if (tick) begin
         cnt_q <= '0;
         lim_q <= lim_next;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/ccd_pow2_div.sv
module ccd_pow2_div #(
   parameter int SEL_W      = 2,
   parameter int FIXED_LOG2 = 3,
   localparam int MAX_LOG2  = (SEL_W > 0) ? ((1 << SEL_W) - 1) : FIXED_LOG2,
   localparam int CNT_W     = (MAX_LOG2 > 0) ? MAX_LOG2 : 1,
   localparam int SEL_PW    = (SEL_W > 0) ? SEL_W : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [SEL_PW-1:0] sel,
   output logic              tick
);

   generate
      if (SEL_W < 0 || SEL_W > 4) begin : g_bad_sel
         $error("ccd_pow2_div: SEL_W must lie in 0..4");
      end
      if (SEL_W == 0 && FIXED_LOG2 < 1) begin : g_bad_fixed
         $error("ccd_pow2_div: FIXED_LOG2 must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;

   generate
      if (SEL_W > 0) begin : g_select
         logic [CNT_W-1:0] lim_q;
         logic [CNT_W-1:0] lim_next;

         // Limit is 2^sel - 1
         always_comb begin
            lim_next = CNT_W'((64'd1 << sel) - 64'd1);
         end

         assign tick = en && (cnt_q == lim_q);

         // The ratio in use is replaced only at the terminal count
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
               lim_q <= '0;
            end else if (tick) begin
               cnt_q <= '0;
               lim_q <= lim_next;
            end else if (en) begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end else begin : g_fixed
         logic unused_sel;

         assign unused_sel = ^sel;
         assign tick       = en && (&cnt_q);

         // Free-running wrap counter
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (en) begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/codec_clock_enables.sv
module codec_clock_enables
   import codec_clk_pkg::*;
#(
   parameter int MCODE_W  = MDIV_CODE_W,
   parameter int SCODE_W  = SDIV_CODE_W,
   parameter int M_MAX    = MDIV_MAX,
   parameter int MOD_L2   = MOD_LOG2,
   parameter int SMP_L2   = SMP_LOG2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [MCODE_W-1:0] mdiv_code,
   input  logic [SCODE_W-1:0] sdiv_code,
   output logic               dev_ce,
   output logic               ser_ce,
   output logic               mod_ce,
   output logic               smp_ce
);

   generate
      if (SMP_L2 < MOD_L2) begin : g_bad_align
         $error("codec_clock_enables: sample stage must be a multiple of the modulator stage");
      end
      if (SCODE_W < 1) begin : g_bad_scode
         $error("codec_clock_enables: serial code needs at least one bit");
      end
   endgenerate

   logic m_tick;
   logic s_tick;
   logic b_tick;
   logic e_tick;

   ccd_master_div #(
      .CODE_W    (MCODE_W),
      .MAX_RATIO (M_MAX)
   ) u_master (
      .clk   (clk),
      .rst_n (rst_n),
      .code  (mdiv_code),
      .tick  (m_tick)
   );

   // Outputs are quiet while reset is held
   assign dev_ce = rst_n & m_tick;

   ccd_pow2_div #(
      .SEL_W      (SCODE_W),
      .FIXED_LOG2 (1)
   ) u_serial (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (dev_ce),
      .sel   (sdiv_code),
      .tick  (s_tick)
   );

   ccd_pow2_div #(
      .SEL_W      (0),
      .FIXED_LOG2 (MOD_L2)
   ) u_mod (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (dev_ce),
      .sel   (1'b0),
      .tick  (b_tick)
   );

   ccd_pow2_div #(
      .SEL_W      (0),
      .FIXED_LOG2 (SMP_L2)
   ) u_smp (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (dev_ce),
      .sel   (1'b0),
      .tick  (e_tick)
   );

   assign ser_ce = s_tick;
   assign mod_ce = b_tick;
   assign smp_ce = e_tick;

endmodule

// File: rtl/codec_clock_enables_chk.sv
module codec_clock_enables_chk (
   input logic clk,
   input logic rst_n,
   input logic dev_ce,
   input logic ser_ce,
   input logic mod_ce,
   input logic smp_ce
);

   logic [7:0] dev_gap;
   logic [7:0] ser_gap;
   logic [7:0] mod_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dev_gap <= '0;
         ser_gap <= '0;
         mod_run <= '0;
      end else begin
         dev_gap <= dev_ce ? 8'd0 : ((dev_gap == 8'hff) ? dev_gap : dev_gap + 8'd1);
         ser_gap <= ser_ce ? 8'd0 : ((ser_gap == 8'hff) ? ser_gap : ser_gap + 8'd1);
         if (smp_ce)
            mod_run <= '0;
         else if (mod_ce && mod_run != 8'hff)
            mod_run <= mod_run + 8'd1;
      end
   end

   // R1: the first cycle after release carries both the device and serial enables
   a_r1_first_tick: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (dev_ce && ser_ce));

   // R2: no device period is longer than five cycles
   a_r2_dev_gap: assert property (@(posedge clk) disable iff (!rst_n)
      dev_gap <= 8'd4);

   // R5: the serial enable never appears without a device tick
   a_r5_ser_sub: assert property (@(posedge clk) disable iff (!rst_n)
      ser_ce |-> dev_ce);

   // R5: no serial period is longer than forty cycles
   a_r5_ser_gap: assert property (@(posedge clk) disable iff (!rst_n)
      ser_gap <= 8'd39);

   // R7: the modulator enable never appears without a device tick
   a_r7_mod_sub: assert property (@(posedge clk) disable iff (!rst_n)
      mod_ce |-> dev_ce);

   // R8: the sample strobe coincides with a modulator enable
   a_r8_smp_sub: assert property (@(posedge clk) disable iff (!rst_n)
      smp_ce |-> mod_ce);

   // R8: thirty-two modulator enables per sample period at most
   a_r8_smp_run: assert property (@(posedge clk) disable iff (!rst_n)
      mod_run <= 8'd31);

endmodule

bind codec_clock_enables codec_clock_enables_chk u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .dev_ce (dev_ce),
   .ser_ce (ser_ce),
   .mod_ce (mod_ce),
   .smp_ce (smp_ce)
);

// File: tb/codec_clock_enables_test.sv
`timescale 1ns/1ps
module codec_clock_enables_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] mdiv_code = 3'd0;
   logic [1:0] sdiv_code = 2'd0;
   logic       dev_ce, ser_ce, mod_ce, smp_ce;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;
   int cycles   = 0;
   int smp_seen = 0;
   int dev_seen = 0;

   // Requirement tags for the current phase
   string dev_tag = "R2";
   string ser_tag = "R5";

   always #4 clk = ~clk;   // 125 MHz

   codec_clock_enables uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .mdiv_code (mdiv_code),
      .sdiv_code (sdiv_code),
      .dev_ce    (dev_ce),
      .ser_ce    (ser_ce),
      .mod_ce    (mod_ce),
      .smp_ce    (smp_ce)
   );

   // Behavioural model: elapsed ticks and the ratio in force
   int m_ratio = 1, m_elapsed = 0;
   int s_ratio = 1, s_elapsed = 0;
   int dev_total = 0;

   function automatic int ratio_of(input logic [2:0] c);
      return (c <= 3'd4) ? int'(c) + 1 : 1;
   endfunction

   function automatic bit exp_dev();
      return rst_n && (m_elapsed == m_ratio - 1);
   endfunction

   function automatic bit exp_ser();
      return exp_dev() && (s_elapsed == s_ratio - 1);
   endfunction

   function automatic bit exp_mod();
      return exp_dev() && ((dev_total % 8) == 7);
   endfunction

   function automatic bit exp_smp();
      return exp_dev() && ((dev_total % 256) == 255);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ratio = 1; m_elapsed = 0;
         s_ratio = 1; s_elapsed = 0;
         dev_total = 0;
      end else begin
         cycles++;
         if (m_elapsed == m_ratio - 1) begin
            if (s_elapsed == s_ratio - 1) begin
               s_elapsed = 0;
               s_ratio   = 1 << sdiv_code;
            end else begin
               s_elapsed++;
            end
            dev_total++;
            m_elapsed = 0;
            m_ratio   = ratio_of(mdiv_code);
         end else begin
            m_elapsed++;
         end
      end
   end

   task automatic check(input string tag, input string what, input bit act, input bit exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s at cycle %0d: actual %0b expected %0b", tag, what, cycles, act, exp);
      end
   endtask

   // Compare on every falling edge
   always @(negedge clk) begin
      if (!done) begin
         if (!rst_n) begin
            check("R1", "dev_ce in reset", dev_ce, 1'b0);
            check("R1", "ser_ce in reset", ser_ce, 1'b0);
            check("R1", "mod_ce in reset", mod_ce, 1'b0);
            check("R1", "smp_ce in reset", smp_ce, 1'b0);
         end else begin
            check(dev_tag, "dev_ce", dev_ce, exp_dev());
            check(ser_tag, "ser_ce", ser_ce, exp_ser());
            check("R7", "mod_ce", mod_ce, exp_mod());
            check("R8", "smp_ce", smp_ce, exp_smp());
            if (smp_ce) smp_seen++;
            if (dev_ce) dev_seen++;
         end
      end
   end

   task automatic run(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // Change a code a given number of cycles after a device tick
   task automatic after_dev(input int offset);
      do @(negedge clk); while (dev_ce !== 1'b1);
      run(offset);
   endtask

   initial begin
      run(5);
      rst_n = 1'b1;
      // R1: first cycle after release
      @(negedge clk);
      check("R1", "dev_ce after release", dev_ce, 1'b1);
      check("R1", "ser_ce after release", ser_ce, 1'b1);
      run(600);

      // R2 with several serial ratios
      for (int c = 1; c <= 4; c++) begin
         mdiv_code = 3'(c);
         sdiv_code = 2'(c - 1);
         run(700);
      end

      // R3: unused codes behave as divide by 1
      dev_tag = "R3";
      for (int c = 5; c <= 7; c++) begin
         mdiv_code = 3'(c);
         run(60);
      end

      // R4: change in mid-period, old ratio completes
      dev_tag = "R4";
      mdiv_code = 3'd4;
      run(20);
      after_dev(2);
      mdiv_code = 3'd2;
      run(30);
      after_dev(1);
      mdiv_code = 3'd0;
      run(30);
      after_dev(0);
      mdiv_code = 3'd3;
      run(40);

      // R6: serial change in mid-period
      ser_tag = "R6";
      sdiv_code = 2'd3;
      run(200);
      after_dev(1);
      sdiv_code = 2'd1;
      run(120);
      sdiv_code = 2'd2;
      run(90);
      sdiv_code = 2'd0;
      run(60);

      // R8: long run at divide by 1 to collect sample strobes
      ser_tag = "R5";
      dev_tag = "R2";
      mdiv_code = 3'd0;
      smp_seen = 0;
      dev_seen = 0;
      run(1024);
      n_checks++;
      if (smp_seen != dev_seen / 256 && smp_seen != dev_seen / 256 + 1) begin
         n_fail++;
         $display("FAIL R8 sample strobe count: actual %0d expected about %0d", smp_seen, dev_seen / 256);
      end

      done = 1'b1;
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      #1000000;
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog expired: actual running expected finished");
         $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule